// File: doc/BRIEF.md
# Serial line code encoder

This block turns a stream of plain binary bits into a line signal in one of four codes: NRZ, NRZI, RZ or Manchester. It runs on a clock at twice the bit rate, so each bit period is made of two half-bit slots. A strobe marks the first slot of every bit. The data bit and the mode are sampled on that strobe. The encoded level is then produced for the first slot and for the second slot.

The line output comes from a flip-flop, so skew on the inputs cannot make it glitch. Every bit is encoded on its own. The only exception is the NRZI reference level, which carries over from one bit to the next. That reference is kept unchanged while the encoder works in any other mode. If no strobe arrives after a bit's second slot, the second-slot level of that bit is held.

Top module: `line_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, `line_out` becomes 0 after that edge, and the NRZI reference level is cleared to 0. A following NRZI bit of 0 is therefore sent as low.
- R2: Mode 2'b00 (NRZ) sends the data bit as the line level in both half-bit slots.
- R3: Mode 2'b01 (NRZI) sends a 0 as the previous reference level and a 1 as its inverse. The new level is held for both slots and becomes the new reference.
- R4: Mode 2'b10 (RZ) sends a 0 as low in both slots. It sends a 1 as high in the first slot and low in the second.
- R5: Mode 2'b11 (Manchester) sends a 0 as low then high, and a 1 as high then low, so the line always changes at mid-bit.
- R6: The level for a slot appears on `line_out` one clock after the edge at which that slot begins. For the first slot, that is the edge that samples `bit_start` high. `line_out` does not change before that edge.
- R7: A change on `mode` while `bit_start` is low has no effect on the current bit. It is taken up only at the next strobe.
- R8: The NRZI reference level is kept across bits sent in other modes.
- R9: `din` is sampled at the strobe. A change of `din` during the second slot does not alter that slot's level. With no new strobe, the second-slot level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Line code select: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| bit_start | input | 1 | High during the first half-bit slot of each bit |
| din | input | 1 | Data bit, sampled with the strobe |
| line_out | output | 1 | Registered encoded line level |

## Verification
The first-slot level is due exactly one clock after the edge that samples `bit_start`. The second-slot level is due one clock later. The bench drives inputs on the falling edge and reads `line_out` on the next falling edge, which is half a cycle after the rising edge that loads it. The latency check also reads the output just after the strobe is applied and before that rising edge, and expects the old level there. Mid-bit changes of `mode` and `din` are applied at the same falling edge where the first-slot level is read, so they act on the second slot's edge.

// File: rtl/line_encoder.sv
module line_encoder (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       bit_start,
  input  logic       din,
  output logic       line_out
);

  localparam logic [1:0] CODE_NRZ  = 2'b00;
  localparam logic [1:0] CODE_NRZI = 2'b01;
  localparam logic [1:0] CODE_RZ   = 2'b10;
  localparam logic [1:0] CODE_MAN  = 2'b11;

  logic [1:0] mode_q;
  logic       din_q;
  logic       ref_lvl;
  logic       ref_next;
  logic       line_q;
  logic       first_lvl;
  logic       second_lvl;

  assign ref_next  = (bit_start && mode == CODE_NRZI) ? (ref_lvl ^ din) : ref_lvl;
  assign first_lvl = (mode == CODE_NRZI) ? ref_next : din;

  always_comb begin
    case (mode_q)
      CODE_NRZ:  second_lvl = din_q;
      CODE_NRZI: second_lvl = ref_lvl;
      CODE_RZ:   second_lvl = 1'b0;
      CODE_MAN:  second_lvl = ~din_q;
      default:   second_lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= CODE_NRZ;
      din_q   <= 1'b0;
      ref_lvl <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      ref_lvl <= ref_next;
      if (bit_start) begin
        mode_q <= mode;
        din_q  <= din;
        line_q <= first_lvl;
      end else begin
        line_q <= second_lvl;
      end
    end
  end

  assign line_out = line_q;

endmodule

// File: rtl/line_encoder_chk.sv
module line_encoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       bit_start,
  input logic       din,
  input logic       line_out
);

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !line_out)
    else $error("R1: line not low after reset");

  p_nrz_first_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_start && mode == 2'b00) |=> (line_out == $past(din)))
    else $error("R2: NRZ first slot wrong");

  p_rz_second_low_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_start && mode == 2'b10) ##1 !bit_start |=> !line_out)
    else $error("R4: RZ second slot not low");

  p_man_first_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_start && mode == 2'b11) |=> (line_out == $past(din)))
    else $error("R5: Manchester first slot wrong");

  p_man_mid_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_start && mode == 2'b11) ##1 !bit_start |=> (line_out != $past(line_out)))
    else $error("R5: Manchester missing mid-bit transition");

  p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (!bit_start && !$past(bit_start) && !$past(rst)) |=> $stable(line_out))
    else $error("R9: level changed without strobe");

endmodule

bind line_encoder line_encoder_chk u_line_encoder_chk (.*);

// File: tb/test_line_encoder.sv
module test_line_encoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       bit_start = 1'b0;
  logic       din = 1'b0;
  logic       line_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  line_encoder i_line_encoder (
    .clk(clk), .rst(rst), .mode(mode),
    .bit_start(bit_start), .din(din), .line_out(line_out)
  );

  // entry: {mode[1:0], din, first-slot level, second-slot level}
  localparam int NVEC = 16;
  localparam logic [4:0] VEC [NVEC] = '{
    {2'b00, 1'b1, 1'b1, 1'b1},
    {2'b00, 1'b0, 1'b0, 1'b0},
    {2'b01, 1'b1, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b0},
    {2'b01, 1'b0, 1'b0, 1'b0},
    {2'b01, 1'b1, 1'b1, 1'b1},
    {2'b10, 1'b1, 1'b1, 1'b0},
    {2'b10, 1'b0, 1'b0, 1'b0},
    {2'b11, 1'b0, 1'b0, 1'b1},
    {2'b11, 1'b1, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b1, 1'b0},
    {2'b00, 1'b0, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input logic exp, input string req);
    checks++;
    if (line_out !== exp) begin
      errors++;
      $display("FAIL %s: line_out=%b expected=%b at %0t", req, line_out, exp, $time);
    end
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // called at a falling edge; returns at a falling edge
  task automatic send(input logic [1:0] m, input logic d, input logic e1, input logic e2, input string req);
    mode = m; din = d; bit_start = 1'b1;
    @(negedge clk);
    check(e1, req);
    bit_start = 1'b0;
    @(negedge clk);
    check(e2, req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expired, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rst = 1'b0;
    @(negedge clk);
    check(1'b0, "R1");

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0], mode_req(VEC[i][4:3]));
    end

    // R8: NRZI reference 1 held across other modes
    send(2'b01, 1'b1, 1'b1, 1'b1, "R3");
    send(2'b10, 1'b1, 1'b1, 1'b0, "R8");
    send(2'b00, 1'b0, 1'b0, 1'b0, "R8");
    send(2'b01, 1'b0, 1'b1, 1'b1, "R8");

    // R1: reset clears reference level
    rst = 1'b1;
    @(negedge clk);
    check(1'b0, "R1");
    rst = 1'b0;
    send(2'b01, 1'b0, 1'b0, 1'b0, "R1");

    // R6: no change before the strobe edge, new level one clock later
    mode = 2'b00; din = 1'b1; bit_start = 1'b1;
    #1 check(1'b0, "R6");
    @(negedge clk);
    check(1'b1, "R6");
    bit_start = 1'b0;
    @(negedge clk);
    check(1'b1, "R6");

    // R7: mode change mid-bit ignored (NRZ 1, switch to RZ)
    mode = 2'b00; din = 1'b1; bit_start = 1'b1;
    @(negedge clk);
    check(1'b1, "R7");
    bit_start = 1'b0; mode = 2'b10;
    @(negedge clk);
    check(1'b1, "R7");
    send(2'b10, 1'b1, 1'b1, 1'b0, "R7");

    // R9: data change mid-bit ignored (Manchester 0)
    mode = 2'b11; din = 1'b0; bit_start = 1'b1;
    @(negedge clk);
    check(1'b0, "R9");
    bit_start = 1'b0; din = 1'b1;
    @(negedge clk);
    check(1'b1, "R9");
    // R9: no strobe keeps second-slot level
    @(negedge clk);
    check(1'b1, "R9");
    @(negedge clk);
    check(1'b1, "R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule